// File: doc/BRIEF.md
# UART receiver with status flags

This block receives asynchronous serial characters on an oversampled line and holds each one in a receive data register for a host to read. It frames each character (a start bit, 8 or 9 data bits sent least significant bit first, and a stop bit) by sampling the line 16 times per bit. Each bit's value is the majority of three samples taken around the bit centre. Alongside the data it keeps five status flags: data-full, idle-line, overrun, noise and framing error.

The host reads the flags and the data through a small registered read port. Reading the status byte and then the data register acknowledges everything that was reported. A character that arrives while the previous one is still unread is dropped and flagged as an overrun. While the overrun is pending, no later character reaches the data register. The idle flag reports a quiet line once per received burst. It is held off while the receiver-wakeup control input is high.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the status byte reads 0x00, the data register reads 0x00 and `rx_bit8` is 0.
- R2: A valid character (start bit 0, data least significant bit first, stop bit 1, 16 ticks per bit) is copied into the data register and sets data-full. In 9-bit mode (`nine_bit`=1) the ninth data bit appears on `rx_bit8`.
- R3: The status byte holds data-full at bit 5, idle at bit 4, overrun at bit 3, noise at bit 2 and framing error at bit 1. Bits 7, 6 and 0 read 0.
- R4: Each bit value is the majority of the samples at ticks 7, 8 and 9 of the bit. If those three samples disagree in any bit of a character, noise is set with that character.
- R5: Framing error is set with a character whose stop-bit vote is 0.
- R6: When a character completes while data-full is set, overrun is set, the character is discarded and the data register keeps its old value.
- R7: While overrun is set, no further character is copied into the data register.
- R8: A data-register read that follows a status read clears data-full, idle, overrun, noise and framing error. A data-register read without a status read since the last clearing read returns the data and clears nothing.
- R9: Idle is set after 160 consecutive high ticks on the line in 8-bit mode, or 176 in 9-bit mode (10 or 11 bit times).
- R10: Idle is not set while `wake_sleep` is high. If the line is still idle and idle is still enabled when `wake_sleep` goes low, idle is set.
- R11: Once idle has been set, it cannot be set again until a character has been copied into the data register. After reset it is enabled.
- R12: If a clearing data read falls in the same cycle as a character completing, the character is copied, data-full stays set and overrun stays clear.
- R13: Reads are registered: `rd_data` shows the selected register one cycle after `rd_en`, with the flags as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Asynchronous serial input, idle high |
| wake_sleep | input | 1 | Receiver-wakeup control; high holds off the idle flag |
| nine_bit | input | 1 | Word length: 0 = 8 data bits, 1 = 9 data bits |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | Read select: 0 = status byte, 1 = data register |
| rd_data | output | 8 | Registered read data |
| rx_bit8 | output | 1 | Ninth data bit of the held character |

## Verification
Two functions can fall in the same cycle: a character completing and a clearing data read. When they coincide, the clear must not turn the completion into an overrun. The bench provokes this by starting a frame on a known negative edge. It places the clearing read on the completion edge, which it derives from the line timing: two synchronizer stages, 16 ticks per bit, the vote at tick 9 of the stop bit and one registered hand-off. It judges the outcome at the ports: the clearing read returns the old byte, the next status read shows data-full without overrun, and the following data read returns the new byte.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  typedef struct packed {
    logic [8:0] data;
    logic       noise;
    logic       frame_err;
  } rx_char_t;

  // status byte bit positions, fixed because host software decodes them
  localparam int ST_FULL  = 5;
  localparam int ST_IDLE  = 4;
  localparam int ST_OVR   = 3;
  localparam int ST_NOISE = 2;
  localparam int ST_FRAME = 1;

  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_DATA   = 1'b1;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b1;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_frame_sampler.sv
module rx_frame_sampler
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     line,
  input  logic     nine_bit,
  output logic     done,
  output rx_char_t char_out
);
  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] PH_A    = PH_W'(OVS / 2 - 1);
  localparam logic [PH_W-1:0] PH_B    = PH_W'(OVS / 2);
  localparam logic [PH_W-1:0] PH_C    = PH_W'(OVS / 2 + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  rx_state_t       state_q;
  logic [PH_W-1:0] phase_q;
  logic [3:0]      bit_idx_q;
  logic [8:0]      shift_q;
  logic            smp_a_q, smp_b_q;
  logic            noise_acc_q;
  logic            done_q;
  rx_char_t        char_q;

  logic vote, disagree;
  logic [3:0] last_idx;

  always_comb begin
    vote     = (smp_a_q & smp_b_q) | (smp_a_q & line) | (smp_b_q & line);
    disagree = !((smp_a_q == smp_b_q) && (smp_b_q == line));
    last_idx = nine_bit ? 4'd8 : 4'd7;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= RX_IDLE;
      phase_q     <= '0;
      bit_idx_q   <= '0;
      shift_q     <= '0;
      smp_a_q     <= 1'b1;
      smp_b_q     <= 1'b1;
      noise_acc_q <= 1'b0;
      done_q      <= 1'b0;
      char_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        if (state_q == RX_IDLE) begin
          if (!line) begin
            state_q     <= RX_START;
            phase_q     <= PH_W'(1);
            noise_acc_q <= 1'b0;
          end
        end else begin
          phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
          if (phase_q == PH_A) smp_a_q <= line;
          if (phase_q == PH_B) smp_b_q <= line;
          if (phase_q == PH_C) begin
            noise_acc_q <= noise_acc_q | disagree;
            case (state_q)
              RX_START: if (vote) state_q <= RX_IDLE;
              RX_DATA:  shift_q <= {vote, shift_q[8:1]};
              RX_STOP: begin
                done_q              <= 1'b1;
                char_q.data         <= nine_bit ? shift_q : {1'b0, shift_q[8:1]};
                char_q.noise        <= noise_acc_q | disagree;
                char_q.frame_err    <= !vote;
                state_q             <= RX_IDLE;
              end
              default: ;
            endcase
          end
          if (phase_q == PH_LAST) begin
            case (state_q)
              RX_START: begin
                state_q   <= RX_DATA;
                bit_idx_q <= '0;
              end
              RX_DATA: begin
                if (bit_idx_q == last_idx) state_q <= RX_STOP;
                else                       bit_idx_q <= bit_idx_q + 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign done     = done_q;
  assign char_out = char_q;

  // R2: a completed character is reported for exactly one cycle
  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line,
  input  logic nine_bit,
  output logic line_idle
);
  localparam int LIM8  = 10 * OVS;
  localparam int LIM9  = 11 * OVS;
  localparam int CNT_W = $clog2(LIM9 + 1);
  localparam logic [CNT_W-1:0] LIMIT8 = CNT_W'(LIM8);
  localparam logic [CNT_W-1:0] LIMIT9 = CNT_W'(LIM9);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  always_comb limit = nine_bit ? LIMIT9 : LIMIT8;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (!line)                   cnt_q <= '0;
    else if (tick && cnt_q != LIMIT9) cnt_q <= cnt_q + 1'b1;
  end

  assign line_idle = (cnt_q >= limit);

  // R9: the quiet-line count never runs past the 9-bit limit
  assert_idle_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT9);

endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       done,
  input  rx_char_t   char_in,
  input  logic       line_idle,
  input  logic       wake_sleep,
  input  logic       rd_en,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic       rx_bit8
);
  logic [8:0] rdr_q;
  logic full_q, idle_q, ovr_q, noise_q, frame_q;
  logic seen_q, armed_q;
  logic [7:0] rd_q;

  logic clr, full_eff, blocked, xfer, ovr_set, idle_set;
  logic [7:0] status_byte;

  always_comb begin
    clr      = rd_en && (rd_sel == SEL_DATA) && seen_q;
    full_eff = full_q && !clr;
    blocked  = ovr_q && !clr;
    xfer     = done && !full_eff && !blocked;
    ovr_set  = done && full_eff;
    idle_set = line_idle && armed_q && !wake_sleep;
    status_byte           = '0;
    status_byte[ST_FULL]  = full_q;
    status_byte[ST_IDLE]  = idle_q;
    status_byte[ST_OVR]   = ovr_q;
    status_byte[ST_NOISE] = noise_q;
    status_byte[ST_FRAME] = frame_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdr_q   <= '0;
      full_q  <= 1'b0;
      idle_q  <= 1'b0;
      ovr_q   <= 1'b0;
      noise_q <= 1'b0;
      frame_q <= 1'b0;
      seen_q  <= 1'b0;
      armed_q <= 1'b1;
      rd_q    <= '0;
    end else begin
      if (xfer) begin
        rdr_q   <= char_in.data;
        full_q  <= 1'b1;
        noise_q <= char_in.noise;
        frame_q <= char_in.frame_err;
      end else if (clr) begin
        full_q  <= 1'b0;
        noise_q <= 1'b0;
        frame_q <= 1'b0;
      end

      if (ovr_set)  ovr_q <= 1'b1;
      else if (clr) ovr_q <= 1'b0;

      if (idle_set) idle_q <= 1'b1;
      else if (clr) idle_q <= 1'b0;

      if (xfer)          armed_q <= 1'b1;
      else if (idle_set) armed_q <= 1'b0;

      if (rd_en && rd_sel == SEL_STATUS) seen_q <= 1'b1;
      else if (clr)                      seen_q <= 1'b0;

      if (rd_en) rd_q <= (rd_sel == SEL_DATA) ? rdr_q[7:0] : status_byte;
    end
  end

  assign rd_data = rd_q;
  assign rx_bit8 = rdr_q[8];

  // R6: overrun is only ever pending on top of a full data register
  assert_ovr_implies_full_R6: assert property (@(posedge clk) disable iff (rst)
    ovr_q |-> full_q);

  // R7: with overrun pending and no clear, the data register holds
  assert_no_transfer_in_ovr_R7: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !clr) |=> $stable(rdr_q));

  // R10: wakeup control high keeps a clear idle flag clear
  assert_idle_held_off_R10: assert property (@(posedge clk) disable iff (rst)
    (wake_sleep && !idle_q) |=> !idle_q);

  // R11: idle rises only when enabled by an earlier transfer or reset
  assert_idle_rearm_R11: assert property (@(posedge clk) disable iff (rst)
    !armed_q |=> !$rose(idle_q));

  // R3: unused status bits read zero
  assert_status_pad_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel == SEL_STATUS) |=> (rd_q[7:6] == 2'b00 && rd_q[0] == 1'b0));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_tick,
  input  logic       rxd,
  input  logic       wake_sleep,
  input  logic       nine_bit,
  input  logic       rd_en,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic       rx_bit8
);
  logic     line_s;
  logic     char_done;
  rx_char_t char_word;
  logic     quiet;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (line_s)
  );

  rx_frame_sampler #(.OVS(OVS)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .tick     (rx_tick),
    .line     (line_s),
    .nine_bit (nine_bit),
    .done     (char_done),
    .char_out (char_word)
  );

  rx_idle_timer #(.OVS(OVS)) u_idle (
    .clk       (clk),
    .rst       (rst),
    .tick      (rx_tick),
    .line      (line_s),
    .nine_bit  (nine_bit),
    .line_idle (quiet)
  );

  rx_status_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .done       (char_done),
    .char_in    (char_word),
    .line_idle  (quiet),
    .wake_sleep (wake_sleep),
    .rd_en      (rd_en),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .rx_bit8    (rx_bit8)
  );

endmodule

// File: tb/uart_rx_status_bench.sv
module uart_rx_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_T = 16;
  localparam int N_VEC = 6;
  localparam logic       V_NINE [N_VEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [8:0] V_DATA [N_VEC] = '{9'h055, 9'h0A3, 9'h03C, 9'h1C5, 9'h0F0, 9'h081};
  localparam logic       V_STOP [N_VEC] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam int         V_GL   [N_VEC] = '{15, 15, 4, 15, 2, 0};
  localparam logic [7:0] V_EXP  [N_VEC] = '{8'h20, 8'h22, 8'h24, 8'h20, 8'h26, 8'h24};

  logic clk = 1'b0, rst = 1'b1, rx_tick = 1'b1, rxd = 1'b1;
  logic wake_sleep = 1'b0, nine_bit = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic rx_bit8;
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] v, coll_v;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_status u_uart_rx_status (
    .clk(clk), .rst(rst), .rx_tick(rx_tick), .rxd(rxd), .wake_sleep(wake_sleep),
    .nine_bit(nine_bit), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .rx_bit8(rx_bit8)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [7:0] val);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    val = rd_data;
  endtask

  task automatic do_reset();
    rst = 1'b1; rxd = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // starts on a negative edge; frame bit 0 is the start bit; gl picks a frame bit whose tick-8 sample is inverted
  task automatic send_frame(input logic nb, input logic [8:0] d, input logic stopv, input int gl);
    int nbits;
    nbits = nb ? 9 : 8;
    for (int b = 0; b < nbits + 2; b++) begin
      logic bv;
      bv = (b == 0) ? 1'b0 : (b == nbits + 1) ? stopv : d[b-1];
      for (int k = 0; k < BIT_T; k++) begin
        rxd = (b == gl && k == 8) ? ~bv : bv;
        @(negedge clk);
      end
    end
    rxd = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    rd(1'b0, v); check("R1 status", v, 8'h00);
    rd(1'b1, v); check("R1 data", v, 8'h00);
    check("R1 bit8", rx_bit8, 1'b0);

    // R9 8-bit idle threshold, R11 enabled after reset
    repeat (142) @(negedge clk);
    rd(1'b0, v); check("R9 before 160 ticks", v, 8'h00);
    repeat (20) @(negedge clk);
    rd(1'b0, v); check("R9 idle after 160 ticks", v, 8'h10);
    rd(1'b1, v);
    rd(1'b0, v); check("R8 idle cleared", v, 8'h00);
    repeat (400) @(negedge clk);
    rd(1'b0, v); check("R11 idle not re-armed", v, 8'h00);
    rd(1'b1, v);

    // R2 R3 R4 R5 R8 R9 R11: vector table
    for (int i = 0; i < N_VEC; i++) begin
      nine_bit = V_NINE[i];
      send_frame(V_NINE[i], V_DATA[i], V_STOP[i], V_GL[i]);
      repeat (4) @(negedge clk);
      rd(1'b0, v); check($sformatf("R3 R4 R5 status vec%0d", i), v, V_EXP[i]);
      rd(1'b1, v); check($sformatf("R2 data vec%0d", i), v, V_DATA[i][7:0]);
      check($sformatf("R2 bit8 vec%0d", i), rx_bit8, V_NINE[i] & V_DATA[i][8]);
      rd(1'b0, v); check($sformatf("R8 cleared vec%0d", i), v, 8'h00);
      repeat (13 * BIT_T) @(negedge clk);
      rd(1'b0, v); check($sformatf("R9 R11 idle re-armed vec%0d", i), v, 8'h10);
      rd(1'b1, v);
    end
    nine_bit = 1'b0;

    // R9 9-bit threshold
    nine_bit = 1'b1;
    do_reset();
    repeat (162) @(negedge clk);
    rd(1'b0, v); check("R9 9-bit before 176 ticks", v, 8'h00);
    repeat (20) @(negedge clk);
    rd(1'b0, v); check("R9 9-bit idle after 176 ticks", v, 8'h10);
    nine_bit = 1'b0;

    // R10 wakeup hold-off
    wake_sleep = 1'b1;
    do_reset();
    repeat (250) @(negedge clk);
    rd(1'b0, v); check("R10 idle held off", v, 8'h00);
    wake_sleep = 1'b0;
    repeat (3) @(negedge clk);
    rd(1'b0, v); check("R10 idle after wake low", v, 8'h10);
    rd(1'b1, v);

    // R6 R7 overrun and blocking
    send_frame(1'b0, 9'h011, 1'b1, 15);
    send_frame(1'b0, 9'h022, 1'b1, 15);
    send_frame(1'b0, 9'h033, 1'b1, 15);
    repeat (4) @(negedge clk);
    rd(1'b0, v); check("R6 overrun status", v, 8'h28);
    rd(1'b1, v); check("R6 R7 first byte kept", v, 8'h11);
    rd(1'b0, v); check("R8 overrun cleared", v, 8'h00);
    rd(1'b1, v);

    // R8 data read without status read clears nothing
    send_frame(1'b0, 9'h044, 1'b1, 15);
    repeat (4) @(negedge clk);
    rd(1'b1, v); check("R8 data without status", v, 8'h44);
    rd(1'b0, v); check("R8 flags kept", v, 8'h20);
    rd(1'b1, v);
    rd(1'b0, v); check("R8 cleared after sequence", v, 8'h00);

    // R12 clearing read on the completion edge
    send_frame(1'b0, 9'h05A, 1'b1, 15);
    repeat (4) @(negedge clk);
    rd(1'b0, v); check("R12 setup status", v, 8'h20);
    fork
      send_frame(1'b0, 9'h0C3, 1'b1, 15);
      begin
        repeat (156) @(negedge clk);
        rd(1'b1, coll_v);
      end
    join
    check("R12 clearing read returns old byte", coll_v, 8'h5A);
    repeat (4) @(negedge clk);
    rd(1'b0, v); check("R12 full without overrun", v, 8'h20);
    rd(1'b1, v); check("R12 new byte", v, 8'hC3);
    rd(1'b0, v); check("R13 R8 final clear", v, 8'h00);

    finish_run();
  end
endmodule